// File: doc/BRIEF.md
# Per-Sector Volatile Lock Array

This block keeps the volatile write protection of a 16 MB flash array split into 256 sectors of 64 KB. Each sector owns two state bits. The write-lock bit, when set, forbids program and erase inside that sector. The lock-down bit, once raised, freezes the write-lock bit and cannot itself be cleared before the next reset.

A command decoder drives one access address, with a write strobe and a data byte. The block returns the lock byte of the addressed sector combinationally. A lock write is accepted only while the write-enable latch is set. Every attempt made with the latch set ends the write and asks the decoder to clear the latch.

A separate check port takes the target address of a pending program or erase and reports whether it is blocked. It can also judge a whole-array erase, which is blocked when any sector is locked. An external protection input, driven by the block-protection logic, is ORed into the verdict.

Top module: `sector_lock_array`

## Requirements
- R1: The sector index is address bits 23..16, giving 256 sectors. A lock write changes only the state of the sector it addresses.
- R2: `rdData` always shows the sector selected by `accAddr`, combinationally. Bit 0 is the write-lock bit, bit 1 is the lock-down bit, and bits 7..2 read 0.
- R3: A write requires `wrStrobe`=1, `welIn`=1 and a lock-down bit of 0 in the addressed sector. Such a write loads `wrData[0]` into write-lock and `wrData[1]` into lock-down at the next rising clock edge. `wrData[7:2]` have no effect.
- R4: A strobe while `welIn`=0 changes no lock state and does not pulse `welClr`.
- R5: A lock-down bit at 1 stays at 1 until reset, whatever data is written later.
- R6: A write to a sector whose lock-down bit is 1 is silently ignored, and both of its bits keep their values.
- R7: `welClr` is high for exactly the one cycle that follows a clock edge at which `wrStrobe` and `welIn` were both 1. This holds whether or not the write was ignored under R6. At all other times `welClr` is low.
- R8: An active-low `rstN` clears every write-lock and lock-down bit.
- R9: With `chkBulk`=0, `blocked` equals the write-lock bit of the sector holding `chkAddr`. A lock-down bit alone does not block.
- R10: With `chkBulk`=1, `blocked` is 1 when any sector has its write-lock bit set.
- R11: `extProtect`=1 forces `blocked` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| accAddr | input | 24 | Address selecting the sector for lock read and write |
| wrStrobe | input | 1 | Lock-byte write request |
| wrData | input | 8 | Lock byte to write |
| welIn | input | 1 | Current state of the write-enable latch |
| welClr | output | 1 | One-cycle request to clear the write-enable latch |
| rdData | output | 8 | Lock byte of the sector at accAddr |
| chkAddr | input | 24 | Target address of a pending program or erase |
| chkBulk | input | 1 | Judge a whole-array erase instead of one sector |
| extProtect | input | 1 | Protection verdict from the block-protection logic |
| blocked | output | 1 | The pending program or erase must be refused |

## Verification
A corrupted write-lock bit shows on `rdData` bit 0 as soon as its sector is addressed. It also shows on `blocked` as soon as `chkAddr` points into that sector, or at once for a whole-array check. A lock-down bit that drops or a frozen write-lock that moves shows on the first read back after the offending edge. A wrong decision on the write-enable latch shows on `welClr` exactly one cycle after the strobe. The bench therefore reads every written sector back one cycle after each write, and it also checks untouched neighbours.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int WL_BIT = 0;
  localparam int LD_BIT = 1;

  // control-to-datapath strobes
  typedef struct packed {
    logic wrEn;
    logic newWl;
    logic newLd;
  } lockStb_t;
endpackage

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import lock_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrStrobe,
  input  logic     welIn,
  input  logic     dataWl,
  input  logic     dataLd,
  input  logic     selLd,
  output lockStb_t stb,
  output logic     welClr
);
  logic attempt;
  assign attempt = wrStrobe & welIn;

  always_comb begin
    stb.wrEn  = attempt & ~selLd;
    stb.newWl = dataWl;
    stb.newLd = dataLd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) welClr <= 1'b0;
    else       welClr <= attempt;
  end
endmodule

// File: rtl/lock_store.sv
module lock_store
  import lock_pkg::*;
#(
  parameter int SECT_W = 8,
  parameter int DATA_W = 8,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  lockStb_t            stb,
  input  logic [SECT_W-1:0]   accSect,
  input  logic [SECT_W-1:0]   chkSect,
  input  logic                chkBulk,
  input  logic                extProtect,
  output logic                selLd,
  output logic [DATA_W-1:0]   rdData,
  output logic                blocked,
  output logic [NUM_SECT-1:0] wlVec,
  output logic [NUM_SECT-1:0] ldVec
);
  logic [NUM_SECT-1:0] hit;

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_dec
    assign hit[s] = stb.wrEn && (accSect == SECT_W'(s));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wlVec <= '0;
      ldVec <= '0;
    end else begin
      for (int s = 0; s < NUM_SECT; s++) begin
        if (hit[s]) begin
          wlVec[s] <= stb.newWl;
          ldVec[s] <= stb.newLd;
        end
      end
    end
  end

  assign selLd = ldVec[accSect];

  always_comb begin
    rdData         = '0;
    rdData[WL_BIT] = wlVec[accSect];
    rdData[LD_BIT] = ldVec[accSect];
  end

  assign blocked = extProtect | (chkBulk ? (|wlVec) : wlVec[chkSect]);
endmodule

// File: rtl/sector_lock_array.sv
module sector_lock_array
  import lock_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SECT_LSB = 16,
  parameter int DATA_W   = 8,
  localparam int SECT_W   = ADDR_W - SECT_LSB,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              welIn,
  output logic              welClr,
  output logic [DATA_W-1:0] rdData,
  input  logic [ADDR_W-1:0] chkAddr,
  input  logic              chkBulk,
  input  logic              extProtect,
  output logic              blocked
);
  lockStb_t            stb;
  logic                selLd;
  logic [NUM_SECT-1:0] wlVec;
  logic [NUM_SECT-1:0] ldVec;
  logic                unusedBits;

  assign unusedBits = ^{accAddr[SECT_LSB-1:0], chkAddr[SECT_LSB-1:0],
                        wrData[DATA_W-1:LD_BIT+1]};

  lock_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .welIn(welIn),
    .dataWl(wrData[WL_BIT]), .dataLd(wrData[LD_BIT]),
    .selLd(selLd), .stb(stb), .welClr(welClr)
  );

  lock_store #(.SECT_W(SECT_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb),
    .accSect(accAddr[ADDR_W-1:SECT_LSB]),
    .chkSect(chkAddr[ADDR_W-1:SECT_LSB]),
    .chkBulk(chkBulk), .extProtect(extProtect),
    .selLd(selLd), .rdData(rdData), .blocked(blocked),
    .wlVec(wlVec), .ldVec(ldVec)
  );
endmodule

// File: rtl/sector_lock_array_chk.sv
module sector_lock_array_chk #(
  parameter int NUM_SECT = 256,
  parameter int DATA_W   = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrStrobe,
  input logic                welIn,
  input logic                welClr,
  input logic                extProtect,
  input logic                blocked,
  input logic [DATA_W-1:0]   rdData,
  input logic [NUM_SECT-1:0] wlVec,
  input logic [NUM_SECT-1:0] ldVec
);
  // R5
  ld_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ldVec & $past(ldVec)) == $past(ldVec));

  // R6
  wl_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((wlVec ^ $past(wlVec)) & $past(ldVec)) == '0);

  // R4
  no_wel_no_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrStrobe && welIn) |-> ($stable(wlVec) && $stable(ldVec)));

  // R7
  wel_clear_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && welIn) |=> welClr);

  // R7
  wel_clear_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStrobe && welIn) |=> !welClr);

  // R11
  ext_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    extProtect |-> blocked);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:2] == '0);
endmodule

bind sector_lock_array sector_lock_array_chk #(.NUM_SECT(NUM_SECT), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .welIn(welIn),
  .welClr(welClr), .extProtect(extProtect), .blocked(blocked),
  .rdData(rdData), .wlVec(wlVec), .ldVec(ldVec)
);

// File: tb/sector_lock_array_bench.sv
module sector_lock_array_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] accAddr = '0;
  logic        wrStrobe = 1'b0;
  logic [7:0]  wrData = '0;
  logic        welIn = 1'b0;
  logic        welClr;
  logic [7:0]  rdData;
  logic [23:0] chkAddr = '0;
  logic        chkBulk = 1'b0;
  logic        extProtect = 1'b0;
  logic        blocked;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  sector_lock_array u_sector_lock_array (
    .clk(clk), .rstN(rstN), .accAddr(accAddr), .wrStrobe(wrStrobe),
    .wrData(wrData), .welIn(welIn), .welClr(welClr), .rdData(rdData),
    .chkAddr(chkAddr), .chkBulk(chkBulk), .extProtect(extProtect),
    .blocked(blocked)
  );

  // {wel, addr[23:0], data[7:0], expected read-back[7:0]}
  localparam logic [40:0] VEC [10] = '{
    {1'b1, 24'h000000, 8'h01, 8'h01},  // R3 lock sector 0
    {1'b1, 24'h00FFFF, 8'h00, 8'h00},  // R1 same sector, other end, unlock
    {1'b0, 24'h050000, 8'h01, 8'h00},  // R4 no latch
    {1'b1, 24'h050000, 8'hFD, 8'h01},  // R3 reserved data bits ignored
    {1'b1, 24'h060000, 8'h03, 8'h03},  // R3 lock plus lock-down
    {1'b1, 24'h060000, 8'h00, 8'h03},  // R6 ignored
    {1'b1, 24'h06ABCD, 8'h02, 8'h03},  // R5 lock-down stays
    {1'b1, 24'hFF1234, 8'h02, 8'h02},  // R1 top sector, lock-down only
    {1'b1, 24'hFF0000, 8'h01, 8'h02},  // R6 write-lock frozen at 0
    {1'b1, 24'h010000, 8'h01, 8'h01}   // R3 sector 1
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic wel, input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    accAddr = a; wrData = d; welIn = wel; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0; welIn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    accAddr = 24'h060000;
    #1 check("R8 reset read", rdData, 8'h00);
    check("R7 idle welClr", {7'b0, welClr}, 8'h00);

    foreach (VEC[i]) begin
      doWrite(VEC[i][40], VEC[i][39:16], VEC[i][15:8]);
      #1;
      check("R2/R3/R5/R6 vector read", rdData, VEC[i][7:0]);
      check("R7/R4 welClr", {7'b0, welClr}, {7'b0, VEC[i][40]});
      @(negedge clk); #1;
      check("R7 welClr single cycle", {7'b0, welClr}, 8'h00);
    end

    // state: s0=0 s1=1 s5=1 s6=3 s255=2
    accAddr = 24'h04FFFF; #1 check("R1 untouched sector 4", rdData, 8'h00);
    accAddr = 24'h070000; #1 check("R1 untouched sector 7", rdData, 8'h00);
    chkAddr = 24'h05ABCD; #1 check("R9 locked sector", {7'b0, blocked}, 8'h01);
    chkAddr = 24'h04ABCD; #1 check("R9 free sector", {7'b0, blocked}, 8'h00);
    chkAddr = 24'hFF0000; #1 check("R9 lock-down alone", {7'b0, blocked}, 8'h00);
    chkBulk = 1'b1;       #1 check("R10 bulk with locks", {7'b0, blocked}, 8'h01);
    chkBulk = 1'b0; extProtect = 1'b1; chkAddr = 24'h040000;
    #1 check("R11 external force", {7'b0, blocked}, 8'h01);
    extProtect = 1'b0;

    doWrite(1'b1, 24'h010000, 8'h00);
    doWrite(1'b1, 24'h050000, 8'h00);
    chkBulk = 1'b1; #1 check("R10 bulk, frozen lock remains", {7'b0, blocked}, 8'h01);
    chkBulk = 1'b0;

    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    accAddr = 24'h060000; #1 check("R8 sector 6 cleared", rdData, 8'h00);
    accAddr = 24'hFF0000; #1 check("R8 sector 255 cleared", rdData, 8'h00);
    chkBulk = 1'b1; #1 check("R10 bulk after reset", {7'b0, blocked}, 8'h00);
    chkBulk = 1'b0;
    doWrite(1'b1, 24'h060000, 8'h01);
    #1 check("R5 reset releases lock-down", rdData, 8'h01);
    chkAddr = 24'h06FFFF; #1 check("R9 newly locked", {7'b0, blocked}, 8'h01);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule